// File: doc/BRIEF.md
# Debug Trigger Comparator

This block sits beside a CPU and watches two streams: the data bus (address, data, direction and a valid strobe) and the execution point of the instruction pipeline (the fetch address of the opcode about to run, plus a queue-flush flag). Two programmable comparators, A and B, are combined by a mode field into one trigger decision. When the trigger fires, the block emits a one-cycle trigger pulse to start a trace. Trace storage is outside the block. Once the trace completes, the block can raise a halt request.

A third comparator, C, is address-only and independent of the trigger logic. It raises a breakpoint either on any bus match or only after the trace run has finished. This lets execution stop some time after capture instead of at the trigger instant.

All settings are loaded through a small write-only register port. Comparators A and B each choose per comparator between force operation, which fires on a bus match in the same cycle, and tag operation, which fires only when the tagged fetch actually begins execution.

Top module: `dbg_trig_unit`

## Requirements
- R1: After reset the armed flag, trigger pulse, halt request and breakpoint output are all low. The register port selects by `cfg_sel`: 0 control, 1 address A, 2 address B, 3 data A, 4 data B, 5 address C. Data registers take the low DATA_W bits.
- R2: Control word bits: 0 arm, 1 halt enable, 5:2 mode, 6 tag A, 7 tag B, 8 C enable, 9 C after-trace, 10 direction check A, 11 direction A, 12 direction check B, 13 direction B, 14 data check A, 15 data check B. `bus_rw` high means read. In force mode, mode 0 pulses `trig_o` in the same cycle as a valid bus cycle whose address equals A. The pulse also requires the enabled direction and data checks to match.
- R3: With tag A set, a bus read at address A only tags the fetch. `trig_o` pulses when `exec_vld` is high with `exec_addr` equal to A while the tag is held. A `q_flush` between fetch and execution drops the tag, so that execution never fires.
- R4: Mode 1 fires on an A match or a B match.
- R5: Modes 2 and 4 fire on a B event seen in a cycle after an A event. Mode 2 uses the full B event, including its data check. Mode 4 uses the B address and direction only. Any write to the control register forgets the earlier A event.
- R6: Mode 5 fires when the bus cycle qualifies on address A and the bus data equals data B. Mode 6 fires when the bus cycle qualifies on address A and the bus data differs from data B.
- R7: Mode 7 fires on a valid cycle (with A's direction check) whose address lies within A..B inclusive. Mode 8 fires when the address lies outside that range.
- R8: Mode 3 fires on B address and direction and ignores B's data check. Codes 9 to 15 never fire, and the armed flag stays set under them.
- R9: Writing the control register loads the armed flag from bit 0, visible the next cycle. A trigger clears it on the following edge. While disarmed, no trigger pulses occur.
- R10: If halt enable is set, a `trace_done` pulse while a trace is running (since the last trigger) sets `halt_req_o` on the next edge. It stays high until `cpu_halted` is seen, and drops on the edge after that.
- R11: With C enabled, `brk_o` pulses in the same cycle as a valid bus cycle at address C. With C after-trace set, the pulse occurs only once a running trace has completed since the last arming write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | ADDR_W | Register write data |
| bus_vld | input | 1 | Bus cycle valid |
| bus_rw | input | 1 | Bus direction, 1 = read |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus data |
| exec_vld | input | 1 | An opcode begins execution this cycle |
| exec_addr | input | ADDR_W | Fetch address of that opcode |
| q_flush | input | 1 | Instruction queue flushed |
| trace_done | input | 1 | Trace capture finished (pulse) |
| cpu_halted | input | 1 | CPU has entered halt |
| trig_o | output | 1 | Trigger pulse |
| halt_req_o | output | 1 | Halt request level |
| armed_o | output | 1 | Trigger logic armed |
| brk_o | output | 1 | Comparator C breakpoint pulse |

## Verification
The hardest case to reach is a tagged fetch that is flushed before it executes. It needs a read at the tag address, then a queue flush, then an execution report for the same address, with the trigger logic still armed at the end. The stimulus performs that sequence cycle by cycle and checks both the absence of a pulse and the still-set armed flag. The delayed breakpoint is a close second. It needs a trigger, a C-address access while the trace is still open, then the completion pulse and a second C access, all within one arming.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

   localparam int CTRL_W = 16;
   localparam int SEL_W  = 3;

   localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_ADR_A = 3'd1;
   localparam logic [SEL_W-1:0] SEL_ADR_B = 3'd2;
   localparam logic [SEL_W-1:0] SEL_DAT_A = 3'd3;
   localparam logic [SEL_W-1:0] SEL_DAT_B = 3'd4;
   localparam logic [SEL_W-1:0] SEL_ADR_C = 3'd5;

   typedef enum logic [3:0] {
      TM_A_ONLY   = 4'd0,
      TM_A_OR_B   = 4'd1,
      TM_A_THEN_B = 4'd2,
      TM_B_EVENT  = 4'd3,
      TM_A_THEN_E = 4'd4,
      TM_A_DAT_B  = 4'd5,
      TM_A_NDAT_B = 4'd6,
      TM_IN_RNG   = 4'd7,
      TM_OUT_RNG  = 4'd8
   } trig_mode_e;

   // control word without the arm bit (bit 0 goes straight to the sequencer)
   typedef struct packed {
      logic       dat_chk_b;
      logic       dat_chk_a;
      logic       dir_b;
      logic       dir_chk_b;
      logic       dir_a;
      logic       dir_chk_a;
      logic       c_after;
      logic       c_en;
      logic       tag_b;
      logic       tag_a;
      logic [3:0] mode;
      logic       halt_en;
   } ctrl_t;

endpackage

// File: rtl/dbg_cmp.sv
module dbg_cmp #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ref_addr,
   input  logic [DATA_W-1:0] ref_data,
   input  logic              data_chk,
   input  logic              tag_en,
   input  logic              rw_ok,
   input  logic              bus_vld,
   input  logic              bus_rw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              exec_vld,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              q_flush,
   output logic              qual,
   output logic              evt
);

   logic addr_eq, force_hit, fetch_hit, tag_fire, tag_q;

   assign addr_eq   = (bus_addr == ref_addr);
   assign qual      = rw_ok && addr_eq;
   assign force_hit = qual && (!data_chk || (bus_data == ref_data));
   assign fetch_hit = tag_en && bus_vld && bus_rw && addr_eq;
   assign tag_fire  = tag_en && tag_q && exec_vld && (exec_addr == ref_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   tag_q <= 1'b0;
      else if (!tag_en)             tag_q <= 1'b0;
      else if (fetch_hit)           tag_q <= 1'b1;
      else if (q_flush || tag_fire) tag_q <= 1'b0;
   end

   assign evt = tag_en ? tag_fire : force_hit;

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
   import dbg_trig_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        mode,
   input  logic              arm_wr,
   input  logic              arm_val,
   input  logic              evt_a,
   input  logic              evt_b,
   input  logic              qual_a,
   input  logic              qual_b,
   input  logic              rw_ok_a,
   input  logic              data_eq_b,
   input  logic [ADDR_W-1:0] lo_addr,
   input  logic [ADDR_W-1:0] hi_addr,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              fire,
   output logic              armed
);

   logic seen_q, armed_q, hit, in_rng, seq_mode;

   assign in_rng   = (bus_addr >= lo_addr) && (bus_addr <= hi_addr);
   assign seq_mode = (mode == TM_A_THEN_B) || (mode == TM_A_THEN_E);

   always_comb begin
      case (trig_mode_e'(mode))
         TM_A_ONLY:   hit = evt_a;
         TM_A_OR_B:   hit = evt_a || evt_b;
         TM_A_THEN_B: hit = seen_q && evt_b;
         TM_B_EVENT:  hit = qual_b;
         TM_A_THEN_E: hit = seen_q && qual_b;
         TM_A_DAT_B:  hit = qual_a && data_eq_b;
         TM_A_NDAT_B: hit = qual_a && !data_eq_b;
         TM_IN_RNG:   hit = rw_ok_a && in_rng;
         TM_OUT_RNG:  hit = rw_ok_a && !in_rng;
         default:     hit = 1'b0;
      endcase
   end

   assign fire  = armed_q && hit;
   assign armed = armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        armed_q <= 1'b0;
      else if (arm_wr)   armed_q <= arm_val;
      else if (fire)     armed_q <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           seen_q <= 1'b0;
      else if (arm_wr || !armed_q)          seen_q <= 1'b0;
      else if (seq_mode && evt_a && !fire)  seen_q <= 1'b1;
   end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
   import dbg_trig_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              bus_vld,
   input  logic              bus_rw,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              exec_vld,
   input  logic [ADDR_W-1:0] exec_addr,
   input  logic              q_flush,
   input  logic              trace_done,
   input  logic              cpu_halted,
   output logic              trig_o,
   output logic              halt_req_o,
   output logic              armed_o,
   output logic              brk_o
);

   localparam int N_CMP = 2;

   if (ADDR_W < CTRL_W) begin : g_bad_addr_w
      $error("ADDR_W must hold the control word");
   end
   if (DATA_W > ADDR_W) begin : g_bad_data_w
      $error("DATA_W may not exceed ADDR_W");
   end

   ctrl_t             ctrl_q;
   logic [ADDR_W-1:0] adr_q [N_CMP+1];
   logic [DATA_W-1:0] dat_q [N_CMP];
   logic              arm_wr, fire, act_q, fin_q, halt_q;
   logic [N_CMP-1:0]  rw_ok_v, qual_v, evt_v, dir_chk_v, dir_v, dat_chk_v, tag_v;

   assign arm_wr = cfg_we && (cfg_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         for (int i = 0; i <= N_CMP; i++) adr_q[i] <= '0;
         for (int i = 0; i < N_CMP; i++)  dat_q[i] <= '0;
      end else if (cfg_we) begin
         case (cfg_sel)
            SEL_CTRL:  ctrl_q   <= ctrl_t'(cfg_wdata[CTRL_W-1:1]);
            SEL_ADR_A: adr_q[0] <= cfg_wdata;
            SEL_ADR_B: adr_q[1] <= cfg_wdata;
            SEL_ADR_C: adr_q[2] <= cfg_wdata;
            SEL_DAT_A: dat_q[0] <= cfg_wdata[DATA_W-1:0];
            SEL_DAT_B: dat_q[1] <= cfg_wdata[DATA_W-1:0];
            default: ;
         endcase
      end
   end

   assign dir_chk_v = {ctrl_q.dir_chk_b, ctrl_q.dir_chk_a};
   assign dir_v     = {ctrl_q.dir_b,     ctrl_q.dir_a};
   assign dat_chk_v = {ctrl_q.dat_chk_b, ctrl_q.dat_chk_a};
   assign tag_v     = {ctrl_q.tag_b,     ctrl_q.tag_a};

   for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
      assign rw_ok_v[g] = bus_vld && (!dir_chk_v[g] || (bus_rw == dir_v[g]));
      dbg_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .ref_addr (adr_q[g]),
         .ref_data (dat_q[g]),
         .data_chk (dat_chk_v[g]),
         .tag_en   (tag_v[g]),
         .rw_ok    (rw_ok_v[g]),
         .bus_vld  (bus_vld),
         .bus_rw   (bus_rw),
         .bus_addr (bus_addr),
         .bus_data (bus_data),
         .exec_vld (exec_vld),
         .exec_addr(exec_addr),
         .q_flush  (q_flush),
         .qual     (qual_v[g]),
         .evt      (evt_v[g])
      );
   end

   dbg_trig_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (ctrl_q.mode),
      .arm_wr   (arm_wr),
      .arm_val  (cfg_wdata[0]),
      .evt_a    (evt_v[0]),
      .evt_b    (evt_v[1]),
      .qual_a   (qual_v[0]),
      .qual_b   (qual_v[1]),
      .rw_ok_a  (rw_ok_v[0]),
      .data_eq_b(bus_data == dat_q[1]),
      .lo_addr  (adr_q[0]),
      .hi_addr  (adr_q[1]),
      .bus_addr (bus_addr),
      .fire     (fire),
      .armed    (armed_o)
   );

   // trace run bookkeeping for halt and the delayed breakpoint
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         fin_q  <= 1'b0;
         halt_q <= 1'b0;
      end else begin
         if (fire)            act_q <= 1'b1;
         else if (trace_done) act_q <= 1'b0;

         if (arm_wr)                   fin_q <= 1'b0;
         else if (act_q && trace_done) fin_q <= 1'b1;

         if (act_q && trace_done && ctrl_q.halt_en) halt_q <= 1'b1;
         else if (cpu_halted)                       halt_q <= 1'b0;
      end
   end

   assign trig_o     = fire;
   assign halt_req_o = halt_q;
   assign brk_o      = ctrl_q.c_en && bus_vld && (bus_addr == adr_q[2])
                       && (!ctrl_q.c_after || fin_q);

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [2:0] cfg_sel,
   input logic       trig_o,
   input logic       armed_o,
   input logic       halt_req_o,
   input logic       cpu_halted,
   input logic       trace_done,
   input logic       brk_o,
   input logic [3:0] mode,
   input logic       c_after,
   input logic       fin
);

   p_trig_needs_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> armed_o);

   p_disarm_after_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o && !(cfg_we && cfg_sel == 3'd0) |=> !armed_o);

   p_reserved_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode >= 4'd9) |-> !trig_o);

   p_halt_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req_o && !cpu_halted |=> halt_req_o);

   p_halt_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halted && !trace_done |=> !halt_req_o);

   p_late_brk_r11: assert property (@(posedge clk) disable iff (!rst_n)
      brk_o && c_after |-> fin);

endmodule

bind dbg_trig_unit dbg_trig_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_we    (cfg_we),
   .cfg_sel   (cfg_sel),
   .trig_o    (trig_o),
   .armed_o   (armed_o),
   .halt_req_o(halt_req_o),
   .cpu_halted(cpu_halted),
   .trace_done(trace_done),
   .brk_o     (brk_o),
   .mode      (ctrl_q.mode),
   .c_after   (ctrl_q.c_after),
   .fin       (fin_q)
);

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;

   localparam int AW = 16;
   localparam int DW = 8;

   localparam logic [15:0] HALT = 16'h0002, TAGA = 16'h0040, CEN = 16'h0100,
                           CAFT = 16'h0200, RWAE = 16'h0400, RWAR = 16'h0800,
                           DAE  = 16'h4000, DBE  = 16'h8000;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0, bus_vld = 0, bus_rw = 0, exec_vld = 0, q_flush = 0;
   logic trace_done = 0, cpu_halted = 0;
   logic [2:0] cfg_sel = '0;
   logic [AW-1:0] cfg_wdata = '0, bus_addr = '0, exec_addr = '0;
   logic [DW-1:0] bus_data = '0;
   logic trig_o, halt_req_o, armed_o, brk_o;

   // staged stimulus, applied at the next falling edge
   logic s_we = 0, s_vld = 0, s_rw = 0, s_ex = 0, s_fl = 0, s_td = 0, s_ch = 0;
   logic [2:0] s_sel = '0;
   logic [AW-1:0] s_wd = '0, s_a = '0, s_ea = '0;
   logic [DW-1:0] s_d = '0;

   typedef struct {
      string      tag;
      logic [3:0] m;   // 0 trig, 1 brk, 2 armed, 3 halt
      logic       et, eb, ea, eh;
   } item_t;
   item_t sb[$];

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_trig_unit #(.ADDR_W(AW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .bus_vld(bus_vld), .bus_rw(bus_rw),
      .bus_addr(bus_addr), .bus_data(bus_data), .exec_vld(exec_vld),
      .exec_addr(exec_addr), .q_flush(q_flush), .trace_done(trace_done),
      .cpu_halted(cpu_halted), .trig_o(trig_o), .halt_req_o(halt_req_o),
      .armed_o(armed_o), .brk_o(brk_o)
   );

   function automatic logic [15:0] ctl(input int md, input logic [15:0] x);
      return x | 16'(md << 2) | 16'h0001;
   endfunction

   task automatic cmp1(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
      end
   endtask

   task automatic step(input string tag, input logic [3:0] m,
                       input logic et, input logic eb, input logic ea, input logic eh);
      item_t it;
      @(negedge clk);
      cfg_we = s_we; cfg_sel = s_sel; cfg_wdata = s_wd;
      bus_vld = s_vld; bus_rw = s_rw; bus_addr = s_a; bus_data = s_d;
      exec_vld = s_ex; exec_addr = s_ea; q_flush = s_fl;
      trace_done = s_td; cpu_halted = s_ch;
      it.tag = tag; it.m = m; it.et = et; it.eb = eb; it.ea = ea; it.eh = eh;
      sb.push_back(it);
      s_we = 0; s_vld = 0; s_ex = 0; s_fl = 0; s_td = 0; s_ch = 0;
   endtask

   task automatic wr(input logic [2:0] sel, input logic [AW-1:0] v);
      s_we = 1; s_sel = sel; s_wd = v;
      step("cfg", 4'b0000, 0, 0, 0, 0);
   endtask

   task automatic bus(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic rw, input logic et);
      s_vld = 1; s_a = a; s_d = d; s_rw = rw;
      step(tag, 4'b0001, et, 0, 0, 0);
   endtask

   task automatic busc(input string tag, input logic [AW-1:0] a, input logic eb);
      s_vld = 1; s_a = a; s_d = '0; s_rw = 1;
      step(tag, 4'b0010, 0, eb, 0, 0);
   endtask

   // monitor: pops one expectation per cycle, samples just before the rising edge
   initial begin
      item_t it;
      forever begin
         @(negedge clk);
         #3;
         if (sb.size() > 0) begin
            it = sb.pop_front();
            if (it.m[0]) cmp1(it.tag, "trig_o", trig_o, it.et);
            if (it.m[1]) cmp1(it.tag, "brk_o", brk_o, it.eb);
            if (it.m[2]) cmp1(it.tag, "armed_o", armed_o, it.ea);
            if (it.m[3]) cmp1(it.tag, "halt_req_o", halt_req_o, it.eh);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      step("R1 reset", 4'b1111, 0, 0, 0, 0);
      bus("R9 unarmed", 16'h1000, 8'h00, 0, 0);
      wr(3'd1, 16'h1000); wr(3'd2, 16'h2000); wr(3'd3, 16'h0055);
      wr(3'd4, 16'h00AA); wr(3'd5, 16'h3000);

      // R2 force match, plain then qualified
      wr(3'd0, ctl(0, 0));
      s_vld = 1; s_a = 16'h1000; s_d = 8'h00; s_rw = 0;
      step("R2 force", 4'b0101, 1, 0, 1, 0);
      step("R9 disarm", 4'b0100, 0, 0, 0, 0);
      wr(3'd0, ctl(0, RWAE | RWAR | DAE));
      bus("R2 data mismatch", 16'h1000, 8'h54, 1, 0);
      bus("R2 wrong dir", 16'h1000, 8'h55, 0, 0);
      bus("R2 qualified", 16'h1000, 8'h55, 1, 1);
      s_vld = 1; s_a = 16'h1000; s_d = 8'h55; s_rw = 1;
      step("R9 ignored", 4'b0101, 0, 0, 0, 0);

      // R3 tag mode
      wr(3'd0, ctl(0, TAGA));
      bus("R3 fetch only", 16'h1000, 8'h00, 1, 0);
      s_ex = 1; s_ea = 16'h1000;
      step("R3 execute", 4'b0001, 1, 0, 0, 0);
      wr(3'd0, ctl(0, TAGA));
      bus("R3 fetch", 16'h1000, 8'h00, 1, 0);
      s_fl = 1;
      step("R3 flush", 4'b0001, 0, 0, 0, 0);
      s_ex = 1; s_ea = 16'h1000;
      step("R3 flushed exec", 4'b0101, 0, 0, 1, 0);

      // R4 either
      wr(3'd0, ctl(1, 0)); bus("R4 B", 16'h2000, 8'h00, 1, 1);
      wr(3'd0, ctl(1, 0)); bus("R4 A", 16'h1000, 8'h00, 1, 1);
      wr(3'd0, ctl(1, 0)); bus("R4 none", 16'h1800, 8'h00, 1, 0);

      // R5 sequences
      wr(3'd0, ctl(2, 0));
      bus("R5 B first", 16'h2000, 8'h00, 1, 0);
      bus("R5 A", 16'h1000, 8'h00, 1, 0);
      bus("R5 then B", 16'h2000, 8'h00, 1, 1);
      wr(3'd0, ctl(2, 0));
      bus("R5 A again", 16'h1000, 8'h00, 1, 0);
      wr(3'd0, ctl(2, 0));
      bus("R5 seen cleared", 16'h2000, 8'h00, 1, 0);
      wr(3'd0, ctl(4, DBE));
      bus("R5 mode4 A", 16'h1000, 8'h00, 1, 0);
      bus("R5 mode4 B no data", 16'h2000, 8'h00, 1, 1);

      // R6 data combinations
      wr(3'd0, ctl(5, 0));
      bus("R6 eq A data", 16'h1000, 8'h55, 1, 0);
      bus("R6 eq B data", 16'h1000, 8'hAA, 1, 1);
      wr(3'd0, ctl(6, 0));
      bus("R6 ne equal", 16'h1000, 8'hAA, 1, 0);
      bus("R6 ne wrong addr", 16'h2000, 8'h11, 1, 0);
      bus("R6 ne hit", 16'h1000, 8'h11, 1, 1);

      // R7 ranges
      wr(3'd0, ctl(7, 0));
      bus("R7 below", 16'h0FFF, 8'h00, 1, 0);
      bus("R7 above", 16'h2001, 8'h00, 1, 0);
      bus("R7 hi edge", 16'h2000, 8'h00, 1, 1);
      wr(3'd0, ctl(7, 0));
      bus("R7 lo edge", 16'h1000, 8'h00, 1, 1);
      wr(3'd0, ctl(8, 0));
      bus("R7 out lo edge", 16'h1000, 8'h00, 1, 0);
      bus("R7 out mid", 16'h1800, 8'h00, 1, 0);
      bus("R7 out above", 16'h2001, 8'h00, 1, 1);

      // R8 event-only B and reserved codes
      wr(3'd0, ctl(3, DBE));
      bus("R8 A ignored", 16'h1000, 8'h00, 1, 0);
      bus("R8 B data ignored", 16'h2000, 8'h00, 1, 1);
      for (int md = 9; md < 16; md += 6) begin
         wr(3'd0, ctl(md, 0));
         bus("R8 reserved A", 16'h1000, 8'h00, 1, 0);
         s_vld = 1; s_a = 16'h2000; s_d = 8'hAA; s_rw = 1;
         step("R8 reserved armed", 4'b0101, 0, 0, 1, 0);
      end

      // R10 halt request
      wr(3'd0, ctl(0, HALT));
      bus("R10 fire", 16'h1000, 8'h00, 1, 1);
      s_td = 1; step("R10 done", 4'b1000, 0, 0, 0, 0);
      step("R10 set", 4'b1000, 0, 0, 0, 1);
      step("R10 held", 4'b1000, 0, 0, 0, 1);
      s_ch = 1; step("R10 ack", 4'b1000, 0, 0, 0, 1);
      step("R10 released", 4'b1000, 0, 0, 0, 0);
      wr(3'd0, ctl(0, 0));
      bus("R10 fire no halt", 16'h1000, 8'h00, 1, 1);
      s_td = 1; step("R10 done", 4'b1000, 0, 0, 0, 0);
      step("R10 disabled", 4'b1000, 0, 0, 0, 0);

      // R11 comparator C
      wr(3'd0, ctl(9, CEN));
      busc("R11 immediate", 16'h3000, 1);
      busc("R11 other addr", 16'h3001, 0);
      wr(3'd0, ctl(0, CEN | CAFT));
      busc("R11 before trace", 16'h3000, 0);
      bus("R11 trigger", 16'h1000, 8'h00, 1, 1);
      busc("R11 trace open", 16'h3000, 0);
      s_td = 1; step("R11 done", 4'b0000, 0, 0, 0, 0);
      busc("R11 after trace", 16'h3000, 1);
      wr(3'd0, ctl(0, 0));
      busc("R11 disabled", 16'h3000, 0);

      step("idle", 4'b0000, 0, 0, 0, 0);
      @(negedge clk);
      #5;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule